// File: doc/BRIEF.md
# Graphics Engine Interrupt Status and Mask Registers

This block is the interrupt-facing register pair of a graphics engine. A 64-bit status word gathers five event flags: signal, finish, horizontal sync, vertical sync, and rectangle-write-end. The same word also carries the sampled display field, the sampled FIFO level, and two fixed identity bytes. A companion mask word holds one mask bit per event. A one-cycle pulse on an event input raises the matching flag. Software clears a flag by writing a one to its bit. The block drives a single registered interrupt request whenever a raised flag is not masked.

The status word also carries two command bits. Writing one to the flush bit or the engine-reset bit produces a one-cycle strobe toward the rest of the engine. The reset command also returns the status word to its reset contents. Neither command bit is stored.

Both registers sit on a simple register bus. The bus has a byte offset, a write enable, 64-bit write data, and combinational read data. The status word is at offset 0x1000 and the mask word is at offset 0x1010.

Top module: `gfx_irq_csr`

## Requirements
- R1: After reset the status word reads 0x551D4000 and the mask word reads 0x7F00. irq_o, flush_stb_o and eng_rst_stb_o are all 0.
- R2: Event inputs map to status bits [4:0] in this order: signal bit 0, finish bit 1, hsync bit 2, vsync bit 3, rect-write-end bit 4. A one-cycle pulse on an input sets its flag, and the flag reads back 1 from the next cycle on.
- R3: Writing the status word clears each flag whose write bit [4:0] is 1. Flags whose write bit is 0 keep their value. Other written bits do not change the flags.
- R4: If an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: The revision byte [23:16] always reads 0x1D and the identity byte [31:24] always reads 0x55. Writes do not change them.
- R6: A mask write keeps only written bits [12:8] as per-event masks, in the flag order of R2. Mask bits [14:13] always read 1 and every other mask bit reads 0.
- R7: irq_o is 1 exactly one cycle after some flag is set while its mask bit is 0.
- R8: Writing 1 to status bit 8 drives flush_stb_o high for exactly one cycle, starting the cycle after the write. Bit 8 reads back 0.
- R9: Writing 1 to status bit 9 drives eng_rst_stb_o high for one cycle. In the same update it returns the status word to its R1 value. The mask word is left unchanged, and bit 9 reads back 0.
- R10: Status bit 13 and bits [15:14] show the field input and the FIFO level input, registered one cycle. The FIFO level encoding is 0 = between empty and almost full, 1 = empty, 2 = almost full, and 3 is reserved.
- R11: Status bits [63:32] read 0. Any offset other than 0x1000 or 0x1010 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 13 | Register byte offset |
| wr_en_i | input | 1 | Write enable |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for addr_i (combinational) |
| evt_set_i | input | 5 | Event pulses, in the order of R2 |
| fifo_lvl_i | input | 2 | FIFO level status |
| field_odd_i | input | 1 | Displayed interlace field |
| flush_stb_o | output | 1 | Flush command strobe |
| eng_rst_stb_o | output | 1 | Engine reset command strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a hardware pulse arriving in the same cycle as a software clear of the same flag. Only that collision decides whether set or clear wins. The bench drives the event pulse and the status write on the same falling edge, so both reach one rising edge together. Other flags are cleared in the same write, to show that the collision is resolved bit by bit. The one-cycle lag of irq_o behind a mask change is reached by unmasking an already pending flag and sampling on both sides of the next edge.

// File: rtl/gfx_irq_pkg.sv
`timescale 1ns/1ps
package gfx_irq_pkg;
  localparam int N_EVT     = 5;
  localparam int BIT_FLUSH = 8;
  localparam int BIT_ERST  = 9;
  localparam int BIT_FIELD = 13;
  localparam int BIT_FIFO  = 14;
  localparam int MSK_LSB   = 8;

  typedef enum logic [1:0] {
    FIFO_MID   = 2'd0,
    FIFO_EMPTY = 2'd1,
    FIFO_AFULL = 2'd2,
    FIFO_RSVD  = 2'd3
  } fifo_lvl_e;
endpackage

// File: rtl/gfx_irq_flags.sv
`timescale 1ns/1ps
module gfx_irq_flags #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         soft_rst_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q, flags_d;

  // set dominates both the w1c clear and the soft reset
  always_comb begin
    if (soft_rst_i) flags_d = set_i;
    else            flags_d = (flags_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((flags_q & $past(clr_i & ~set_i)) == '0)); // R3
endmodule

// File: rtl/gfx_irq_mask.sv
`timescale 1ns/1ps
module gfx_irq_mask #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '1;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q)); // R6
endmodule

// File: rtl/gfx_irq_gate.sv
`timescale 1ns/1ps
module gfx_irq_gate #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flags_i & ~mask_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gfx_irq_csr.sv
`timescale 1ns/1ps
module gfx_irq_csr
  import gfx_irq_pkg::*;
#(
  parameter int          ADDR_W   = 13,
  parameter int          DATA_W   = 64,
  parameter logic [12:0] STAT_OFS = 13'h1000,
  parameter logic [12:0] MASK_OFS = 13'h1010,
  parameter logic [7:0]  REV_VAL  = 8'h1D,
  parameter logic [7:0]  ID_VAL   = 8'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_EVT-1:0]  evt_set_i,
  input  logic [1:0]        fifo_lvl_i,
  input  logic              field_odd_i,
  output logic              flush_stb_o,
  output logic              eng_rst_stb_o,
  output logic              irq_o
);
  localparam int HI_W = DATA_W - 32;

  logic sel_stat, sel_mask, wr_stat, wr_mask, soft_rst;
  logic [N_EVT-1:0] evt_flags, evt_mask, clr_vec;
  logic [1:0] fifo_q;
  logic       field_q, flush_q, erst_q;
  logic       wdata_unused;

  assign sel_stat = (addr_i == ADDR_W'(STAT_OFS));
  assign sel_mask = (addr_i == ADDR_W'(MASK_OFS));
  assign wr_stat  = wr_en_i & sel_stat;
  assign wr_mask  = wr_en_i & sel_mask;
  assign soft_rst = wr_stat & wdata_i[BIT_ERST];
  assign clr_vec  = wr_stat ? wdata_i[N_EVT-1:0] : '0;
  assign wdata_unused = ^{wdata_i[DATA_W-1:MSK_LSB+N_EVT], wdata_i[MSK_LSB-1:N_EVT]};

  gfx_irq_flags #(.N(N_EVT)) u_flags (
    .clk_i, .rst_ni, .set_i(evt_set_i), .clr_i(clr_vec),
    .soft_rst_i(soft_rst), .flags_o(evt_flags));

  gfx_irq_mask #(.N(N_EVT)) u_mask (
    .clk_i, .rst_ni, .wr_i(wr_mask),
    .wdata_i(wdata_i[MSK_LSB +: N_EVT]), .mask_o(evt_mask));

  gfx_irq_gate #(.N(N_EVT)) u_gate (
    .clk_i, .rst_ni, .flags_i(evt_flags), .mask_i(evt_mask), .irq_o);

  // sampled status inputs, returned to reset value by the reset command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_q  <= FIFO_EMPTY;
      field_q <= 1'b0;
    end else if (soft_rst) begin
      fifo_q  <= FIFO_EMPTY;
      field_q <= 1'b0;
    end else begin
      fifo_q  <= fifo_lvl_i;
      field_q <= field_odd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= 1'b0;
      erst_q  <= 1'b0;
    end else begin
      flush_q <= wr_stat & wdata_i[BIT_FLUSH];
      erst_q  <= soft_rst;
    end
  end

  assign flush_stb_o   = flush_q;
  assign eng_rst_stb_o = erst_q;

  always_comb begin
    rdata_o = '0;
    if (sel_stat) begin
      rdata_o[N_EVT-1:0]         = evt_flags;
      rdata_o[BIT_FIELD]         = field_q;
      rdata_o[BIT_FIFO +: 2]     = fifo_q;
      rdata_o[23:16]             = REV_VAL;
      rdata_o[31:24]             = ID_VAL;
    end else if (sel_mask) begin
      rdata_o[MSK_LSB +: N_EVT]  = evt_mask;
      rdata_o[MSK_LSB+N_EVT +: 2] = 2'b11;
    end
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|evt_flags)); // R7

  AST_SOFT_RST_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst && !(|evt_set_i)) |=> (evt_flags == '0 && fifo_q == FIFO_EMPTY)); // R9

  AST_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1 -: HI_W] == '0); // R11
endmodule

// File: tb/gfx_irq_csr_tb.sv
`timescale 1ns/1ps
module gfx_irq_csr_tb;
  localparam logic [12:0] A_ST = 13'h1000;
  localparam logic [12:0] A_MK = 13'h1010;

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 flush, 3 eng reset
    logic [63:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [12:0] addr = A_ST;
  logic        wr_en = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [4:0]  evt = '0;
  logic [1:0]  fifo = 2'd1;
  logic        field = 1'b0;
  logic        flush_stb, erst_stb, irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  item_t q[$];
  event smp;

  always #5 clk = ~clk;

  gfx_irq_csr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .evt_set_i(evt),
    .fifo_lvl_i(fifo), .field_odd_i(field),
    .flush_stb_o(flush_stb), .eng_rst_stb_o(erst_stb), .irq_o(irq));

  function automatic logic [63:0] st(input logic [4:0] f, input logic fl,
                                     input logic [1:0] ff);
    return {32'h0, 8'h55, 8'h1D, ff, fl, 8'h00, f};
  endfunction

  // monitor: pops expectations and compares with observed outputs
  initial forever begin
    @(smp);
    #0.2;
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {63'h0, irq};
        2: act = {63'h0, flush_stb};
        default: act = {63'h0, erst_stb};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [12:0] a,
                     input logic [63:0] e, input string r);
    item_t it;
    addr = a;
    it.kind = kind; it.exp = e; it.req = r;
    q.push_back(it);
    -> smp;
    #0.4;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a, input logic [63:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input logic [4:0] m);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(0, A_ST, 64'h551D4000, "R1 status");
    chk(0, A_MK, 64'h7F00, "R1 mask");
    chk(1, A_ST, 0, "R1 irq");
    chk(2, A_ST, 0, "R1 flush");
    chk(3, A_ST, 0, "R1 eng reset");

    // R10 sampled field / fifo level
    field = 1'b1; fifo = 2'd0;
    step();
    chk(0, A_ST, st(5'h00, 1'b1, 2'd0), "R10 field odd, fifo mid");
    fifo = 2'd2;
    step();
    chk(0, A_ST, st(5'h00, 1'b1, 2'd2), "R10 fifo almost full");

    // R2 event pulses
    pulse(5'h04);
    chk(0, A_ST, st(5'h04, 1'b1, 2'd2), "R2 hsync flag");
    pulse(5'h11);
    chk(0, A_ST, st(5'h15, 1'b1, 2'd2), "R2 signal+rect flags");
    chk(1, A_ST, 0, "R7 masked no irq");

    // R3 w1c with noise in other bits; R5 read-only bytes; R11 upper zero
    wr(A_ST, 64'hFFFF_FFFF_FF00_00E1);
    chk(0, A_ST, st(5'h14, 1'b1, 2'd2), "R3 clear bit0 only / R5 / R11");

    // R4 set and clear collide on bit4
    evt = 5'h10;
    wr(A_ST, 64'h14);
    evt = '0;
    chk(0, A_ST, st(5'h10, 1'b1, 2'd2), "R4 set wins");

    // R6 mask write keeps [12:8]; R7 one-cycle irq lag
    wr(A_MK, 64'h1000_FFFF_FFFF_EF00);
    chk(0, A_MK, 64'h6F00, "R6 mask readback");
    chk(1, A_ST, 0, "R7 irq lags mask");
    step();
    chk(1, A_ST, 1, "R7 irq asserted");
    wr(A_MK, 64'h0);
    chk(0, A_MK, 64'h6000, "R6 forced bits");
    wr(A_ST, 64'h1F);
    chk(0, A_ST, st(5'h00, 1'b1, 2'd2), "R3 clear all");
    chk(1, A_ST, 1, "R7 irq lags flag");
    step();
    chk(1, A_ST, 0, "R7 irq dropped");

    // R8 flush strobe
    wr(A_ST, 64'h100);
    chk(2, A_ST, 1, "R8 flush strobe");
    chk(3, A_ST, 0, "R8 no eng reset");
    chk(0, A_ST, st(5'h00, 1'b1, 2'd2), "R8 bit8 reads 0");
    step();
    chk(2, A_ST, 0, "R8 strobe one cycle");

    // R9 engine reset command
    pulse(5'h03);
    wr(A_ST, 64'h200);
    chk(3, A_ST, 1, "R9 eng reset strobe");
    chk(0, A_ST, 64'h551D4000, "R9 status to reset value");
    chk(0, A_MK, 64'h6000, "R9 mask kept");
    step();
    chk(3, A_ST, 0, "R9 strobe one cycle");
    chk(0, A_ST, st(5'h00, 1'b1, 2'd2), "R10 resampled after reset");

    // R11 unmapped offset
    chk(0, 13'h1008, 0, "R11 unmapped reads 0");

    step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule